// File: doc/BRIEF.md
# Boundary-Synchronized Receiver Error Status

This block collects seven error and status indications from a digital audio receiver and holds them in a sticky error register that software reads. The framing decoder, the CRC checkers and the lock detector sit elsewhere. They hand this block their raw results on plain input pins, together with three framing strobes: one per sub-frame, one per channel-status block, and one per subcode block. Each flag takes a new sample only on the strobe of its own framing unit. Between strobes, changes on its raw input are ignored.

A flag that samples 1 stays set until a read. A read normally clears the whole register. In level interrupt mode, a read leaves set every bit whose most recent sample is still 1. Per-bit enables hide flags: a disabled flag reads 0 and cannot be captured while it is disabled. The OR of the visible bits drives a single error line, which the interrupt logic uses as one of its status inputs.

Top module: `rx_err_status`

## Requirements
- R1: After reset, `err_stat_o` is 0 and `err_any_o` is 0.
- R2: Parity (bit 0), bi-phase (bit 1), confidence (bit 2) and validity (bit 3) take a new sample only on a clock edge where `sf_stb_i` is high. The block or subcode strobes leave them unchanged.
- R3: The unlock flag (bit 4, 1 = out of lock) takes a new sample only on an edge where `cs_stb_i` is high.
- R4: The channel-status CRC flag (bit 5) samples on `cs_stb_i`. When `pro_mode_i` is 0 its sample is forced to 0.
- R5: The subcode CRC flag (bit 6) takes a new sample only on an edge where `q_stb_i` is high.
- R6: Once a bit is set, a later sample of 0 does not clear it. Only a read can clear it.
- R7: With `level_mode_i` = 0, an edge with `rd_clr_i` high and no strobe for a bit clears that bit, visible from the next cycle.
- R8: With `level_mode_i` = 1, such a read leaves each bit equal to its most recent sample. A bit whose latest sample is 0 clears, and a bit whose latest sample is 1 stays set.
- R9: When a bit's strobe and `rd_clr_i` fall on the same edge, the bit takes the new sample. The clear does not win.
- R10: A bit with `err_mask_i` = 0 reads as 0 at once. A flag sampled while disabled stays 0 after it is enabled again, until its next strobe.
- R11: `err_any_o` is 1 exactly when some bit of `err_stat_o` is 1, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| sf_stb_i | input | 1 | Sub-frame boundary strobe |
| cs_stb_i | input | 1 | Channel-status block boundary strobe |
| q_stb_i | input | 1 | Subcode block boundary strobe |
| parity_err_i | input | 1 | Raw parity error |
| biphase_err_i | input | 1 | Raw bi-phase coding error |
| conf_err_i | input | 1 | Raw confidence error |
| validity_i | input | 1 | Raw received validity bit |
| unlock_i | input | 1 | Raw out-of-lock indication |
| cs_crc_err_i | input | 1 | Raw channel-status CRC error |
| q_crc_err_i | input | 1 | Raw subcode CRC error |
| pro_mode_i | input | 1 | Professional channel-status format active |
| level_mode_i | input | 1 | Level interrupt mode selected |
| err_mask_i | input | 7 | Per-bit enable, 1 = visible |
| rd_clr_i | input | 1 | Register read strobe (clear on read) |
| err_stat_o | output | 7 | Error register |
| err_any_o | output | 1 | OR of visible error bits |

## Verification
Two things can land on the same edge: a framing strobe that samples a flag, and a register read that clears it. Directed cases issue a read together with a sub-frame strobe whose parity and bi-phase samples differ from the held bits. The expected result is that the bits equal the new samples. The random phase raises both strobes and reads often, so they coincide many times in pulse mode and in level mode. In each such cycle the register is compared with a bench model that gives the sample priority over the clear.

// File: rtl/rxes_pkg.sv
package rxes_pkg;
  localparam int NFLAG    = 7;
  localparam int B_PAR    = 0;
  localparam int B_BIP    = 1;
  localparam int B_CONF   = 2;
  localparam int B_VAL    = 3;
  localparam int B_UNLK   = 4;
  localparam int B_CSCRC  = 5;
  localparam int B_QCRC   = 6;

  typedef enum logic [1:0] {
    MARK_SUBFRAME = 2'd0,
    MARK_CSBLK    = 2'd1,
    MARK_QBLK     = 2'd2
  } frame_mark_e;

  // Which framing strobe samples a given flag.
  function automatic frame_mark_e mark_of(input int idx);
    if (idx == B_QCRC) return MARK_QBLK;
    if (idx == B_UNLK || idx == B_CSCRC) return MARK_CSBLK;
    return MARK_SUBFRAME;
  endfunction

  // The channel-status CRC only counts in professional format.
  function automatic logic pro_gate(input int idx, input logic raw, input logic pro);
    if (idx == B_CSCRC) return raw & pro;
    return raw;
  endfunction

  // Next sticky value: a sample beats a clear on the same edge.
  function automatic logic sticky_next(input logic cur, input logic src,
                                       input logic smp, input logic upd,
                                       input logic rd,  input logic lvl);
    if (upd) return rd ? smp : (cur | smp);
    if (rd)  return lvl ? src : 1'b0;
    return cur;
  endfunction
endpackage

// File: rtl/rxes_sample_gate.sv
module rxes_sample_gate #(
  parameter int N = rxes_pkg::NFLAG
) (
  input  logic [N-1:0] raw_i,
  input  logic [N-1:0] mask_i,
  input  logic         pro_i,
  input  logic         sf_stb_i,
  input  logic         cs_stb_i,
  input  logic         q_stb_i,
  output logic [N-1:0] smp_o,
  output logic [N-1:0] upd_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    assign smp_o[g] = rxes_pkg::pro_gate(g, raw_i[g], pro_i) & mask_i[g];
    if (rxes_pkg::mark_of(g) == rxes_pkg::MARK_QBLK) begin : g_q
      assign upd_o[g] = q_stb_i;
    end else if (rxes_pkg::mark_of(g) == rxes_pkg::MARK_CSBLK) begin : g_cs
      assign upd_o[g] = cs_stb_i;
    end else begin : g_sf
      assign upd_o[g] = sf_stb_i;
    end
  end
endmodule

// File: rtl/rxes_flag_cell.sv
module rxes_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic smp_i,
  input  logic upd_i,
  input  logic rd_i,
  input  logic lvl_i,
  input  logic mask_i,
  output logic sticky_o,
  output logic src_o,
  output logic bit_o
);
  logic sticky_q, src_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      sticky_q <= 1'b0;
      src_q    <= 1'b0;
    end else begin
      sticky_q <= rxes_pkg::sticky_next(sticky_q, src_q, smp_i, upd_i, rd_i, lvl_i);
      if (upd_i) src_q <= smp_i;
    end
  end

  assign sticky_o = sticky_q;
  assign src_o    = src_q;
  assign bit_o    = sticky_q & mask_i;
endmodule

// File: rtl/rx_err_status.sv
module rx_err_status (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sf_stb_i,
  input  logic       cs_stb_i,
  input  logic       q_stb_i,
  input  logic       parity_err_i,
  input  logic       biphase_err_i,
  input  logic       conf_err_i,
  input  logic       validity_i,
  input  logic       unlock_i,
  input  logic       cs_crc_err_i,
  input  logic       q_crc_err_i,
  input  logic       pro_mode_i,
  input  logic       level_mode_i,
  input  logic [6:0] err_mask_i,
  input  logic       rd_clr_i,
  output logic [6:0] err_stat_o,
  output logic       err_any_o
);
  localparam int N = rxes_pkg::NFLAG;

  // Named internal events, brought out for the checker.
  logic [N-1:0] raw_vec;
  logic [N-1:0] smp_vec;
  logic [N-1:0] upd_vec;
  logic [N-1:0] sticky_vec;
  logic [N-1:0] src_vec;
  logic [N-1:0] stat_vec;

  always_comb begin
    raw_vec                   = '0;
    raw_vec[rxes_pkg::B_PAR]   = parity_err_i;
    raw_vec[rxes_pkg::B_BIP]   = biphase_err_i;
    raw_vec[rxes_pkg::B_CONF]  = conf_err_i;
    raw_vec[rxes_pkg::B_VAL]   = validity_i;
    raw_vec[rxes_pkg::B_UNLK]  = unlock_i;
    raw_vec[rxes_pkg::B_CSCRC] = cs_crc_err_i;
    raw_vec[rxes_pkg::B_QCRC]  = q_crc_err_i;
  end

  rxes_sample_gate #(.N(N)) u_gate (
    .raw_i    (raw_vec),
    .mask_i   (err_mask_i),
    .pro_i    (pro_mode_i),
    .sf_stb_i (sf_stb_i),
    .cs_stb_i (cs_stb_i),
    .q_stb_i  (q_stb_i),
    .smp_o    (smp_vec),
    .upd_o    (upd_vec)
  );

  for (genvar g = 0; g < N; g++) begin : g_cell
    rxes_flag_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .smp_i    (smp_vec[g]),
      .upd_i    (upd_vec[g]),
      .rd_i     (rd_clr_i),
      .lvl_i    (level_mode_i),
      .mask_i   (err_mask_i[g]),
      .sticky_o (sticky_vec[g]),
      .src_o    (src_vec[g]),
      .bit_o    (stat_vec[g])
    );
  end

  assign err_stat_o = stat_vec;
  assign err_any_o  = |stat_vec;
endmodule

// File: rtl/rxes_checker.sv
module rxes_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sf_stb_i,
  input logic       cs_stb_i,
  input logic       q_stb_i,
  input logic       parity_err_i,
  input logic       pro_mode_i,
  input logic       level_mode_i,
  input logic       rd_clr_i,
  input logic [6:0] err_mask_i,
  input logic [6:0] err_stat_o,
  input logic       err_any_o,
  input logic [6:0] sticky_vec,
  input logic [6:0] src_vec
);
  assert_sub_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sf_stb_i && !rd_clr_i) |=> (sticky_vec[3:0] == $past(sticky_vec[3:0])));

  assert_unlock_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_stb_i && !rd_clr_i) |=> (sticky_vec[4] == $past(sticky_vec[4])));

  assert_cscrc_pro_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_stb_i && !pro_mode_i) |=> !src_vec[5]);

  assert_q_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!q_stb_i && !rd_clr_i) |=> (sticky_vec[6] == $past(sticky_vec[6])));

  assert_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_clr_i |=> ((sticky_vec & $past(sticky_vec)) == $past(sticky_vec)));

  assert_pulse_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && !level_mode_i && !sf_stb_i && !cs_stb_i && !q_stb_i) |=> (sticky_vec == 7'd0));

  assert_level_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && level_mode_i && !sf_stb_i && !cs_stb_i && !q_stb_i) |=> (sticky_vec == $past(src_vec)));

  assert_sample_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && sf_stb_i) |=> (sticky_vec[0] == $past(parity_err_i & err_mask_i[0])));

  assert_masked_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((err_stat_o & ~err_mask_i) == 7'd0));

  assert_any_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_any_o == (err_stat_o != 7'd0)));
endmodule

bind rx_err_status rxes_checker u_rxes_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sf_stb_i     (sf_stb_i),
  .cs_stb_i     (cs_stb_i),
  .q_stb_i      (q_stb_i),
  .parity_err_i (parity_err_i),
  .pro_mode_i   (pro_mode_i),
  .level_mode_i (level_mode_i),
  .rd_clr_i     (rd_clr_i),
  .err_mask_i   (err_mask_i),
  .err_stat_o   (err_stat_o),
  .err_any_o    (err_any_o),
  .sticky_vec   (sticky_vec),
  .src_vec      (src_vec)
);

// File: tb/rx_err_status_tb_top.sv
module rx_err_status_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sf_stb = 0, cs_stb = 0, q_stb = 0;
  logic [6:0] raw = '0;          // {q, cs, unlock, val, conf, bip, par}
  logic pro = 0, lvl = 0, rd = 0;
  logic [6:0] mask = '1;
  logic [6:0] stat;
  logic any;

  logic [6:0] m_st = '0, m_src = '0;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_err_status dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .sf_stb_i(sf_stb), .cs_stb_i(cs_stb), .q_stb_i(q_stb),
    .parity_err_i(raw[0]), .biphase_err_i(raw[1]), .conf_err_i(raw[2]),
    .validity_i(raw[3]), .unlock_i(raw[4]), .cs_crc_err_i(raw[5]),
    .q_crc_err_i(raw[6]), .pro_mode_i(pro), .level_mode_i(lvl),
    .err_mask_i(mask), .rd_clr_i(rd), .err_stat_o(stat), .err_any_o(any)
  );

  // Strobe that owns each bit: q for bit 6, cs for bits 5..4, sub-frame for 3..0.
  function automatic logic [6:0] owner_strobes(input logic s, input logic c, input logic q);
    return {q, c, c, s, s, s, s};
  endfunction

  function automatic logic [6:0] gated_sample(input logic [6:0] r, input logic [6:0] m, input logic p);
    logic [6:0] keep;
    keep = 7'h7f;
    keep[5] = p;
    return r & m & keep;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [6:0] act, input logic [6:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_advance();
    logic [6:0] up, sm, with_stb, no_stb;
    up = owner_strobes(sf_stb, cs_stb, q_stb);
    sm = gated_sample(raw, mask, pro);
    with_stb = rd ? sm : (m_st | sm);
    no_stb   = rd ? (lvl ? m_src : 7'd0) : m_st;
    m_st  = (up & with_stb) | (~up & no_stb);
    m_src = (up & sm) | (~up & m_src);
  endtask

  // Inputs already set at a negedge; apply one edge and compare against the model.
  task automatic step(input string tag);
    logic [6:0] exp;
    model_advance();
    @(posedge clk);
    @(negedge clk);
    exp = m_st & mask;
    check(stat == exp, tag, stat, exp);
    check(any == (exp != 0), "R11", {6'd0, any}, {6'd0, exp != 0});
    sf_stb = 0; cs_stb = 0; q_stb = 0; rd = 0;
  endtask

  task automatic lit(input string tag, input logic [6:0] exp);
    check(stat == exp, tag, stat, exp);
  endtask

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0a17));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    lit("R1", 7'd0);
    check(any == 1'b0, "R1", {6'd0, any}, 7'd0);

    // R3 / R4: cs strobe with pro off -> only unlock.
    raw = 7'h7f; cs_stb = 1; step("R4");
    lit("R4", 7'b0010000);
    pro = 1; cs_stb = 1; step("R4");
    lit("R3", 7'b0110000);
    q_stb = 1; step("R5");
    lit("R5", 7'b1110000);
    sf_stb = 1; step("R2");
    lit("R2", 7'b1111111);
    raw = 0; sf_stb = 1; cs_stb = 1; q_stb = 1; step("R6");
    lit("R6", 7'b1111111);
    rd = 1; step("R7");
    lit("R7", 7'd0);

    // R8: level mode keeps bits whose latest sample is 1.
    raw = 7'b0010001; sf_stb = 1; cs_stb = 1; step("R8");
    raw = 7'b0010000; sf_stb = 1; step("R6");
    lit("R6", 7'b0010001);
    lvl = 1; rd = 1; step("R8");
    lit("R8", 7'b0010000);
    lvl = 0; rd = 1; step("R7");
    lit("R7", 7'd0);

    // R9: sample beats clear on the same edge.
    raw = 7'b0000001; sf_stb = 1; step("R9");
    raw = 7'b0000010; sf_stb = 1; rd = 1; step("R9");
    lit("R9", 7'b0000010);
    raw = 7'b0000001; sf_stb = 1; rd = 1; step("R9");
    lit("R9", 7'b0000001);
    rd = 1; step("R7");

    // R10: disabled flag reads 0 and is not captured.
    mask = 7'b1111110; raw = 7'b0000001; sf_stb = 1; step("R10");
    lit("R10", 7'd0);
    check(any == 1'b0, "R11", {6'd0, any}, 7'd0);
    raw = 0; mask = '1; step("R10");
    lit("R10", 7'd0);
    raw = 7'b0001000; sf_stb = 1; step("R2");
    mask = 7'b1110111; #1;
    lit("R10", 7'd0);
    mask = '1; #1;
    lit("R10", 7'b0001000);
    check(any == 1'b1, "R11", {6'd0, any}, 7'd1);
    @(negedge clk);

    // Random phase.
    for (int i = 0; i < 3000; i++) begin
      string tag;
      raw    = 7'($urandom);
      sf_stb = ($urandom % 3) == 0;
      cs_stb = ($urandom % 5) == 0;
      q_stb  = ($urandom % 5) == 0;
      rd     = ($urandom % 4) == 0;
      if (($urandom % 16) == 0) pro = ~pro;
      if (($urandom % 16) == 0) lvl = ~lvl;
      mask = (($urandom % 4) == 0) ? 7'($urandom) : 7'h7f;
      if (rd && (sf_stb || cs_stb || q_stb)) tag = "R9";
      else if (rd) tag = lvl ? "R8" : "R7";
      else tag = "R6";
      step(tag);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule